// File: doc/BRIEF.md
# Watchdog Countdown Timer with APB Register Access

The block is a 32-bit watchdog sitting on an APB bus. A down-counter advances by one on every pulse of a tick-enable input, and it can be refilled from a load register. When the count lands on zero, a raw interrupt flag is set. On the next tick the counter refills and keeps counting. Software services the watchdog by writing to an interrupt-clear register. That write drops the flag and refills the counter.

One control bit serves two purposes: it lets the counter run, and it gates the interrupt output. Setting that bit from clear refills the counter at once. Clearing it freezes the count where it stands. A second control bit arms a reset request. The request is a single-cycle pulse, issued when the counter reaches zero again before software has cleared the flag. A build-time parameter selects a locking variant. In that variant, the control register stops accepting writes once the counter has been enabled, and only a system reset releases it.

The control bits are held by a small state machine with three named states:
- `ST_OFF`: counter stopped.
- `ST_ON`: running, still writable.
- `ST_LOCKED`: running, control frozen.

It has three named transitions:
- `arm`: `ST_OFF` goes to `ST_ON`, or to `ST_LOCKED` in the locking variant, when a control write sets the enable bit.
- `disarm`: `ST_ON` goes to `ST_OFF` when a control write clears it.
- `hold`: `ST_LOCKED` stays in `ST_LOCKED`.

Top module: `wdt_apb`

## Requirements
- R1: After reset, the load register (offset 0x00) and the count (offset 0x04) read 0xFFFFFFFF. The control register (0x08) reads 0, the raw flag (0x10) reads 0, and `irq_o` and `rst_req_o` are low.
- R2: While control bit 0 (enable) is 0, tick pulses leave the count unchanged.
- R3: While enable is 1, each tick pulse lowers the count by one.
- R4: A write to offset 0x00 stores the data as the load value and sets the count to it in the same cycle, whether or not enable is set.
- R5: A control write that changes enable from 0 to 1 sets the count to the load value. A control write that clears enable freezes the count at its present value.
- R6: A tick that brings the count from 1 to 0 sets the raw flag (bit 0 at offset 0x10). The next tick refills the count from the load value, and counting goes on.
- R7: Any write to offset 0x0C, whatever its data, clears the raw flag and refills the count from the load value.
- R8: With LOCK_ON_ENABLE=1, once enable has been set, later control writes are ignored. Control keeps reading 1 and the count keeps running until reset.
- R9: If control bit 1 (reset arm) is 1 and a tick brings the count from 1 to 0 while the raw flag is already set, `rst_req_o` is high for exactly the one following cycle.
- R10: `irq_o` and bit 0 at offset 0x14 both equal the raw flag AND enable. Control reads back enable in bit 0 and reset arm in bit 1.
- R11: Transfers complete with `pready_o` high and `pslverr_o` low. Reads of offsets 0x0C and 0x18 and above return 0. Writes to offsets 0x04, 0x10, 0x14 and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| tick_en | input | 1 | Count-advance pulse, one clock wide per tick |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | ADDR_W (12) | APB byte address |
| pwdata_i | input | DATA_W (32) | APB write data |
| prdata_o | output | DATA_W (32) | APB read data |
| pready_o | output | 1 | Always high, no wait states |
| pslverr_o | output | 1 | Always low |
| irq_o | output | 1 | Interrupt: raw flag AND enable |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
On every cycle, the embedded properties check the following:
- the count holds, decrements or refills exactly as the stimulus of that cycle dictates;
- load and clear writes act on the next cycle;
- the locked state never leaves and never lets a control write through;
- a reset request appears only with the raw flag set, and lasts only one cycle.

Other behaviours can only be shown by the bench's scenarios. These include the reset values seen through the bus and the full wrap from load value through zero back to load value. They also include the second-expiry reset request, freezing and resuming through enable, and the locking variant surviving a disable write and then releasing on system reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // Word indices (byte offset / 4) of the register map
    localparam int unsigned IDX_LOAD  = 0;
    localparam int unsigned IDX_VALUE = 1;
    localparam int unsigned IDX_CTRL  = 2;
    localparam int unsigned IDX_CLR   = 3;
    localparam int unsigned IDX_RIS   = 4;
    localparam int unsigned IDX_MIS   = 5;

    // Control bit positions
    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_RSTEN = 1;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ON     = 2'd1,
        ST_LOCKED = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [DATA_W-1:0] load_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic              en_i,
    input  logic              rsten_i,
    input  logic              ris_i,
    output logic              wr_load_o,
    output logic              wr_ctrl_o,
    output logic              wr_clr_o,
    output logic [DATA_W-1:0] prdata_o
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word;
    logic             wr_hit;
    logic [1:0]       unused_byte_lanes;

    assign word              = paddr_i[ADDR_W-1:2];
    assign unused_byte_lanes = paddr_i[1:0];
    assign wr_hit            = psel_i && penable_i && pwrite_i;

    assign wr_load_o = wr_hit && (word == IDX_W'(IDX_LOAD));
    assign wr_ctrl_o = wr_hit && (word == IDX_W'(IDX_CTRL));
    assign wr_clr_o  = wr_hit && (word == IDX_W'(IDX_CLR));

    always_comb begin
        prdata_o = '0;
        if (word == IDX_W'(IDX_LOAD)) begin
            prdata_o = load_i;
        end else if (word == IDX_W'(IDX_VALUE)) begin
            prdata_o = value_i;
        end else if (word == IDX_W'(IDX_CTRL)) begin
            prdata_o[BIT_EN]    = en_i;
            prdata_o[BIT_RSTEN] = rsten_i;
        end else if (word == IDX_W'(IDX_RIS)) begin
            prdata_o[0] = ris_i;
        end else if (word == IDX_W'(IDX_MIS)) begin
            prdata_o[0] = ris_i && en_i;
        end
    end
endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
#(
    parameter bit LOCK_ON_ENABLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl_i,
    input  logic en_bit_i,
    input  logic rsten_bit_i,
    output logic en_o,
    output logic rsten_o,
    output logic start_o
);
    ctrl_state_e state_q, state_d, arm_state;
    logic        rsten_q;

    generate
        if (LOCK_ON_ENABLE) begin : g_lock
            assign arm_state = ST_LOCKED;
        end else begin : g_free
            assign arm_state = ST_ON;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (wr_ctrl_i && en_bit_i)  state_d = arm_state;  // arm
            ST_ON:     if (wr_ctrl_i && !en_bit_i) state_d = ST_OFF;     // disarm
            ST_LOCKED: state_d = ST_LOCKED;                              // hold
            default:   state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            rsten_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_ctrl_i && state_q != ST_LOCKED) rsten_q <= rsten_bit_i;
        end
    end

    always_comb begin
        en_o    = (state_q != ST_OFF);
        rsten_o = rsten_q;
        start_o = (state_q == ST_OFF) && wr_ctrl_i && en_bit_i;
    end

    // R8: a locked controller ignores control writes
    a_r8_lock_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && wr_ctrl_i) |=> (en_o && $stable(rsten_q)));

    // R5: a start pulse leaves the counter enabled
    a_r5_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> en_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              rsten_i,
    input  logic              wr_load_i,
    input  logic              wr_clr_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] value_o,
    output logic              ris_o,
    output logic              rst_req_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] load_q, value_q;
    logic              ris_q, req_q;
    logic              any_wr, step, expire;

    assign any_wr = wr_load_i || wr_clr_i || start_i;
    assign step   = en_i && tick_i && !any_wr;
    assign expire = step && (value_q == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= '1;
            value_q <= '1;
            ris_q   <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (wr_load_i) begin
                load_q  <= wdata_i;
                value_q <= wdata_i;
            end else if (wr_clr_i || start_i) begin
                value_q <= load_q;
            end else if (step) begin
                value_q <= (value_q == '0) ? load_q : value_q - ONE;
            end
            if (wr_clr_i) begin
                ris_q <= 1'b0;
            end else if (expire) begin
                ris_q <= 1'b1;
                req_q <= ris_q && rsten_i;
            end
        end
    end

    assign load_o    = load_q;
    assign value_o   = value_q;
    assign ris_o     = ris_q;
    assign rst_req_o = req_q;

    // R2: disabled counter holds
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !wr_load_i && !wr_clr_i && !start_i) |=> $stable(value_q));

    // R3: enabled tick decrements a nonzero count
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step && value_q != '0) |=> (value_q == $past(value_q) - ONE));

    // R6: tick at zero refills from load
    a_r6_refill_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && value_q == '0) |=> (value_q == $past(load_q)));

    // R4: load write sets load and count
    a_r4_load_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load_i |=> (value_q == $past(wdata_i) && load_q == $past(wdata_i)));

    // R7: clear write drops the flag and refills
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr_i |=> (!ris_q && value_q == $past(load_q)));

    // R9: request only with the flag set, one cycle wide
    a_r9_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> ris_q);
    a_r9_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/wdt_apb.sv
module wdt_apb
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W         = 12,
    parameter int unsigned DATA_W         = 32,
    parameter bit          LOCK_ON_ENABLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [DATA_W-1:0] pwdata_i,
    output logic [DATA_W-1:0] prdata_o,
    output logic              pready_o,
    output logic              pslverr_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic              wr_load, wr_ctrl, wr_clr;
    logic              en, rsten, start, ris;
    logic [DATA_W-1:0] load_v, value_v;

    wdt_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .psel_i    (psel_i),
        .penable_i (penable_i),
        .pwrite_i  (pwrite_i),
        .paddr_i   (paddr_i),
        .load_i    (load_v),
        .value_i   (value_v),
        .en_i      (en),
        .rsten_i   (rsten),
        .ris_i     (ris),
        .wr_load_o (wr_load),
        .wr_ctrl_o (wr_ctrl),
        .wr_clr_o  (wr_clr),
        .prdata_o  (prdata_o)
    );

    wdt_ctrl_fsm #(.LOCK_ON_ENABLE(LOCK_ON_ENABLE)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl_i   (wr_ctrl),
        .en_bit_i    (pwdata_i[BIT_EN]),
        .rsten_bit_i (pwdata_i[BIT_RSTEN]),
        .en_o        (en),
        .rsten_o     (rsten),
        .start_o     (start)
    );

    wdt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_en),
        .en_i      (en),
        .rsten_i   (rsten),
        .wr_load_i (wr_load),
        .wr_clr_i  (wr_clr),
        .start_i   (start),
        .wdata_i   (pwdata_i),
        .load_o    (load_v),
        .value_o   (value_v),
        .ris_o     (ris),
        .rst_req_o (rst_req_o)
    );

    assign irq_o     = ris && en;
    assign pready_o  = 1'b1;
    assign pslverr_o = 1'b0;

    // R10: interrupt never raised while disabled
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !start) |=> !irq_o);
endmodule

// File: tb/sim_wdt_apb.sv
module sim_wdt_apb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        psel0 = 1'b0, psel1 = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata0, prdata1;
    logic        pready0, pready1, pslverr0, pslverr1;
    logic        irq0, irq1, rreq0, rreq1;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model of u0
    logic [31:0] m_load, m_val;
    logic        m_en, m_rsten, m_ris, m_req;

    always #10 clk = ~clk;

    wdt_apb #(.LOCK_ON_ENABLE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel_i(psel0),
        .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
        .prdata_o(prdata0), .pready_o(pready0), .pslverr_o(pslverr0),
        .irq_o(irq0), .rst_req_o(rreq0));

    wdt_apb #(.LOCK_ON_ENABLE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel_i(psel1),
        .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
        .prdata_o(prdata1), .pready_o(pready1), .pslverr_o(pslverr1),
        .irq_o(irq1), .rst_req_o(rreq1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return m_load;
            12'h004: return m_val;
            12'h008: return {30'd0, m_rsten, m_en};
            12'h010: return {31'd0, m_ris};
            12'h014: return {31'd0, m_ris & m_en};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_load = '1; m_val = '1; m_en = 0; m_rsten = 0; m_ris = 0; m_req = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // write to u0 (which=0) or u1 (which=1); model tracks u0 only
    task automatic apb_wr(input bit which, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        paddr = a; pwdata = d; pwrite = 1'b1; penable = 1'b0;
        psel0 = !which; psel1 = which;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel0 = 0; psel1 = 0; penable = 0; pwrite = 0;
        if (!which) begin
            case (a)
                12'h000: begin m_load = d; m_val = d; end
                12'h008: begin
                    if (!m_en && d[0]) m_val = m_load;
                    m_en = d[0]; m_rsten = d[1];
                end
                12'h00C: begin m_ris = 0; m_val = m_load; end
                default: ;
            endcase
        end
    endtask

    task automatic apb_rd(input bit which, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        paddr = a; pwrite = 1'b0; penable = 1'b0;
        psel0 = !which; psel1 = which;
        @(negedge clk); penable = 1'b1;
        #1 d = which ? prdata1 : prdata0;
        @(negedge clk); psel0 = 0; psel1 = 0; penable = 0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a);
        logic [31:0] d;
        apb_rd(1'b0, a, d);
        chk(req, d, exp_rd(a));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            m_req = 0;
            if (m_en) begin
                if (m_val == 0) m_val = m_load;
                else begin
                    if (m_val == 1) begin m_req = m_ris & m_rsten; m_ris = 1; end
                    m_val = m_val - 1;
                end
            end
            @(negedge clk); tick_en = 1'b0;
            chk("R9 rst_req", {31'd0, rreq0}, {31'd0, m_req});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog timeout: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset defaults
        rd_chk("R1 load", 12'h000);
        rd_chk("R1 value", 12'h004);
        rd_chk("R1 ctrl", 12'h008);
        rd_chk("R1 ris", 12'h010);
        chk("R1 irq", {31'd0, irq0}, 32'd0);
        chk("R1 rst_req", {31'd0, rreq0}, 32'd0);

        // R2 disabled: ticks ignored
        ticks(5);
        chk("R2 value held", m_val, 32'hFFFF_FFFF);
        rd_chk("R2 value", 12'h004);

        // R4 load write while disabled
        apb_wr(0, 12'h000, 32'd10);
        rd_chk("R4 value follows load", 12'h004);

        // R3 enable and count
        apb_wr(0, 12'h008, 32'd1);
        ticks(3);
        chk("R3 model", m_val, 32'd7);
        rd_chk("R3 value", 12'h004);

        // R5 freeze then re-enable reloads
        apb_wr(0, 12'h008, 32'd0);
        ticks(4);
        rd_chk("R5 frozen", 12'h004);
        apb_wr(0, 12'h008, 32'd1);
        rd_chk("R5 reload on enable", 12'h004);

        // R6 reach zero, flag, refill
        ticks(10);
        rd_chk("R6 value zero", 12'h004);
        rd_chk("R6 ris set", 12'h010);
        chk("R10 irq", {31'd0, irq0}, 32'd1);
        rd_chk("R10 mis", 12'h014);
        ticks(1);
        chk("R6 refill model", m_val, 32'd10);
        rd_chk("R6 refill", 12'h004);

        // R7 clear with arbitrary data
        ticks(4);
        apb_wr(0, 12'h00C, 32'hDEAD_BEEF);
        rd_chk("R7 ris cleared", 12'h010);
        rd_chk("R7 value refilled", 12'h004);

        // R9 second expiry with reset arm
        apb_wr(0, 12'h000, 32'd2);
        apb_wr(0, 12'h008, 32'd3);
        rd_chk("R10 ctrl bits", 12'h008);
        ticks(5);
        chk("R9 model fired", {31'd0, m_ris}, 32'd1);

        // R11 map details
        rd_chk("R11 clr reads zero", 12'h00C);
        rd_chk("R11 unmapped", 12'h018);
        apb_wr(0, 12'h004, 32'd77);
        apb_wr(0, 12'h010, 32'd0);
        apb_wr(0, 12'h01C, 32'd5);
        rd_chk("R11 value untouched", 12'h004);
        rd_chk("R11 ris untouched", 12'h010);
        chk("R11 pready", {31'd0, pready0}, 32'd1);
        chk("R11 pslverr", {31'd0, pslverr0}, 32'd0);

        // R8 locking variant on u1
        apb_wr(1, 12'h000, 32'd100);
        apb_wr(1, 12'h008, 32'd1);
        ticks(3);
        apb_rd(1, 12'h004, d); chk("R8 running", d, 32'd97);
        apb_wr(1, 12'h008, 32'd0);
        ticks(2);
        apb_rd(1, 12'h004, d); chk("R8 still running", d, 32'd95);
        apb_wr(1, 12'h008, 32'd2);
        apb_rd(1, 12'h008, d); chk("R8 ctrl locked", d, 32'd1);
        do_reset();
        apb_rd(1, 12'h008, d); chk("R8 ctrl after reset", d, 32'd0);
        apb_rd(1, 12'h004, d); chk("R8 value after reset", d, 32'hFFFF_FFFF);
        rd_chk("R1 value after reset", 12'h004);

        // random mix on u0
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1, 2, 3, 4: ticks($urandom_range(1, 3));
                5: apb_wr(0, 12'h000, 32'($urandom_range(0, 12)));
                6: apb_wr(0, 12'h008, 32'($urandom_range(0, 3)));
                7: apb_wr(0, 12'h00C, $urandom);
                8: rd_chk("R3 random read", 12'($urandom_range(0, 7) * 4));
                default: apb_wr(0, 12'($urandom_range(4, 7) * 4) & 12'h01C, $urandom);
            endcase
            if (op == 9) rd_chk("R11 random ignored write", 12'h004);
            chk("R10 random irq", {31'd0, irq0}, {31'd0, m_ris & m_en});
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule